// File: doc/BRIEF.md
# Calendar Time Counter with Masked Alarm

This block holds wall-clock time as seven separate binary fields: second, minute, hour, day of month, day of week, month and year. The year is kept as an offset from 2000, which covers 2000 to 2127. A one-cycle pulse arrives once per second and advances the fields with all carries, including the month lengths and leap years. A separate alarm record is compared against the time each time a pulse arrives. A seven-bit mask can drop any field from that comparison.

Alarm and tick events each set a status bit. A pulse reading the status clears it. An enable word selects which events drive an active-low interrupt line, and a one-shot option disarms the alarm after it fires once. The time, the alarm record, the mask and the enable word are each written through a one-cycle load strobe with a parallel value. The bus that produces these strobes and the oscillator divider that makes the tick are outside the block.

Top module: `cal_alarm_rtc`

## Requirements
- R1: Each tick advances seconds 0..59. At 59 the seconds wrap to 0 and the minutes advance (0..59). At minute 59 the minutes wrap and the hours advance (0..23). With no tick and no load, the time holds.
- R2: The day of month runs from 1 to the month length: 30 for months 4, 6, 9 and 11, and 31 for the other months. February has 29 days when the year offset is divisible by 4, otherwise 28. Past the last day, the day returns to 1 and the month advances.
- R3: The day of week (0..6) advances whenever the hours wrap from 23 to 0. It wraps from 6 to 0.
- R4: After month 12, the month returns to 1 and the year offset advances. The year offset wraps from 127 to 0.
- R5: Packed time and alarm words use these bit positions: second [5:0], minute [11:6], hour [16:12], day of month [21:17], day of week [24:22], month [28:25], year offset [35:29]. A time load replaces the time on the next edge and takes priority over a tick in the same cycle.
- R6: The alarm matches on a tick when every unmasked field of the advanced time equals its alarm field. Mask bit 0 drops seconds, 1 minutes, 2 hours, 3 day of month, 4 day of week, 5 month and 6 year. A match sets status bit 0 only while enable bit 0 is 1.
- R7: When enable bit 2 (one-shot) is 1, a firing alarm clears enable bit 0 on the same edge, so later matches set no status. With bit 2 at 0, the alarm fires again on every match.
- R8: Status bit 1 is set by every tick. A read pulse clears both status bits. An event arriving in the same cycle as a read wins, and its bit stays 1.
- R9: The interrupt output is low while status bit 0 is 1, or while status bit 1 and enable bit 1 are both 1. Otherwise it is high.
- R10: Reset gives 2000-01-01 00:00:00 with day of week 0. The status, enable word, mask and alarm record are all zero, and the interrupt output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, once per second |
| time_load_i | input | 1 | Load strobe for the time |
| time_wdata_i | input | 36 | Packed time to load |
| alarm_load_i | input | 1 | Load strobe for the alarm record |
| alarm_wdata_i | input | 36 | Packed alarm record |
| mask_load_i | input | 1 | Load strobe for the alarm mask |
| mask_wdata_i | input | 7 | Field mask, 1 drops the field |
| en_load_i | input | 1 | Load strobe for the enable word |
| en_wdata_i | input | 3 | Enable word: alarm, tick, one-shot |
| status_rd_i | input | 1 | Read pulse, clears status |
| time_o | output | 36 | Current packed time |
| status_o | output | 2 | Status: bit 0 alarm, bit 1 tick |
| irq_n_o | output | 1 | Interrupt, active low |

## Verification
The range assertions assume that every loaded time contains legal field values: seconds and minutes below 60, hours below 24, a day that exists in its month, a weekday below 7 and a month from 1 to 12. The assertions also assume the tick is a one-cycle pulse. The directed stimulus loads only such calendar values and drives every strobe for exactly one cycle. The rollover checks start from loaded values just before each boundary rather than counting through long spans.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int SEC_W  = 6;
   localparam int MIN_W  = 6;
   localparam int HOUR_W = 5;
   localparam int MDAY_W = 5;
   localparam int WDAY_W = 3;
   localparam int MON_W  = 4;
   localparam int YEAR_W = 7;
   localparam int NUM_FIELDS = 7;
   localparam int TIME_W = SEC_W + MIN_W + HOUR_W + MDAY_W + WDAY_W + MON_W + YEAR_W;

   localparam int STA_W = 2;
   localparam int EN_W  = 3;
   localparam int STA_ALARM = 0;
   localparam int STA_TICK  = 1;
   localparam int EN_ALARM  = 0;
   localparam int EN_TICK   = 1;
   localparam int EN_ONCE   = 2;

   // mask bit positions
   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HOUR = 2;
   localparam int F_MDAY = 3;
   localparam int F_WDAY = 4;
   localparam int F_MON  = 5;
   localparam int F_YEAR = 6;

   typedef logic [SEC_W-1:0]  sec_t;
   typedef logic [MIN_W-1:0]  min_t;
   typedef logic [HOUR_W-1:0] hour_t;
   typedef logic [MDAY_W-1:0] mday_t;
   typedef logic [WDAY_W-1:0] wday_t;
   typedef logic [MON_W-1:0]  mon_t;
   typedef logic [YEAR_W-1:0] year_t;

   typedef struct packed {
      year_t year;
      mon_t  month;
      wday_t wday;
      mday_t mday;
      hour_t hour;
      min_t  min;
      sec_t  sec;
   } cal_time_t;

   localparam sec_t  SEC_LAST   = sec_t'(59);
   localparam min_t  MIN_LAST   = min_t'(59);
   localparam hour_t HOUR_LAST  = hour_t'(23);
   localparam wday_t WDAY_LAST  = wday_t'(6);
   localparam mday_t MDAY_FIRST = mday_t'(1);
   localparam mon_t  MON_FIRST  = mon_t'(1);
   localparam mon_t  MON_LAST   = mon_t'(12);

   localparam cal_time_t TIME_RESET = '{year: '0, month: MON_FIRST, wday: '0,
                                        mday: MDAY_FIRST, hour: '0, min: '0, sec: '0};

   function automatic mday_t month_len(input mon_t m, input logic leap);
      case (m)
         mon_t'(4), mon_t'(6), mon_t'(9), mon_t'(11): month_len = mday_t'(30);
         mon_t'(2): month_len = leap ? mday_t'(29) : mday_t'(28);
         default:   month_len = mday_t'(31);
      endcase
   endfunction

endpackage

// File: rtl/cal_counter.sv
module cal_counter
   import rtc_cal_pkg::*;
#(
   parameter int LEAP_EVERY = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick_i,
   input  logic      load_i,
   input  cal_time_t load_val_i,
   output cal_time_t time_o,
   output cal_time_t next_o
);

   cal_time_t cur_q;
   cal_time_t nxt;
   logic      leap;
   mday_t     last_day;

   generate
      if (LEAP_EVERY == 0) begin : g_no_leap
         assign leap = 1'b0;
      end else begin : g_leap
         localparam year_t LEAP_MASK = year_t'(LEAP_EVERY - 1);
         assign leap = ((cur_q.year & LEAP_MASK) == '0);
      end
   endgenerate

   assign last_day = month_len(cur_q.month, leap);

   always_comb begin
      nxt = cur_q;
      if (cur_q.sec != SEC_LAST) begin
         nxt.sec = cur_q.sec + sec_t'(1);
      end else begin
         nxt.sec = '0;
         if (cur_q.min != MIN_LAST) begin
            nxt.min = cur_q.min + min_t'(1);
         end else begin
            nxt.min = '0;
            if (cur_q.hour != HOUR_LAST) begin
               nxt.hour = cur_q.hour + hour_t'(1);
            end else begin
               nxt.hour = '0;
               nxt.wday = (cur_q.wday == WDAY_LAST) ? '0 : cur_q.wday + wday_t'(1);
               if (cur_q.mday != last_day) begin
                  nxt.mday = cur_q.mday + mday_t'(1);
               end else begin
                  nxt.mday = MDAY_FIRST;
                  if (cur_q.month != MON_LAST) begin
                     nxt.month = cur_q.month + mon_t'(1);
                  end else begin
                     nxt.month = MON_FIRST;
                     nxt.year  = cur_q.year + year_t'(1);
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= TIME_RESET;
      end else if (load_i) begin
         cur_q <= load_val_i;
      end else if (tick_i) begin
         cur_q <= nxt;
      end
   end

   assign time_o = cur_q;
   assign next_o = nxt;

endmodule

// File: rtl/alarm_match.sv
module alarm_match
   import rtc_cal_pkg::*;
(
   input  cal_time_t             cand_i,
   input  cal_time_t             alarm_i,
   input  logic [NUM_FIELDS-1:0] mask_i,
   output logic                  hit_o
);

   logic [NUM_FIELDS-1:0] eq;
   logic [NUM_FIELDS-1:0] keep;

   assign eq[F_SEC]  = (cand_i.sec   == alarm_i.sec);
   assign eq[F_MIN]  = (cand_i.min   == alarm_i.min);
   assign eq[F_HOUR] = (cand_i.hour  == alarm_i.hour);
   assign eq[F_MDAY] = (cand_i.mday  == alarm_i.mday);
   assign eq[F_WDAY] = (cand_i.wday  == alarm_i.wday);
   assign eq[F_MON]  = (cand_i.month == alarm_i.month);
   assign eq[F_YEAR] = (cand_i.year  == alarm_i.year);

   generate
      for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
         assign keep[i] = eq[i] | mask_i[i];
      end
   endgenerate

   assign hit_o = &keep;

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
   import rtc_cal_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             match_i,
   input  logic             rd_i,
   input  logic             en_load_i,
   input  logic [EN_W-1:0]  en_wdata_i,
   output logic [EN_W-1:0]  en_o,
   output logic [STA_W-1:0] sta_o,
   output logic             irq_n_o
);

   logic [EN_W-1:0]  en_q;
   logic [STA_W-1:0] sta_q;
   logic             fire;

   assign fire = match_i & en_q[EN_ALARM];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (en_load_i) begin
         en_q <= en_wdata_i;
      end else if (fire && en_q[EN_ONCE]) begin
         en_q[EN_ALARM] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sta_q <= '0;
      end else begin
         if (fire)      sta_q[STA_ALARM] <= 1'b1;
         else if (rd_i) sta_q[STA_ALARM] <= 1'b0;
         if (tick_i)    sta_q[STA_TICK]  <= 1'b1;
         else if (rd_i) sta_q[STA_TICK]  <= 1'b0;
      end
   end

   assign en_o    = en_q;
   assign sta_o   = sta_q;
   assign irq_n_o = ~(sta_q[STA_ALARM] | (sta_q[STA_TICK] & en_q[EN_TICK]));

endmodule

// File: rtl/cal_alarm_rtc.sv
module cal_alarm_rtc
   import rtc_cal_pkg::*;
#(
   parameter int LEAP_EVERY = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick_i,
   input  logic                  time_load_i,
   input  logic [TIME_W-1:0]     time_wdata_i,
   input  logic                  alarm_load_i,
   input  logic [TIME_W-1:0]     alarm_wdata_i,
   input  logic                  mask_load_i,
   input  logic [NUM_FIELDS-1:0] mask_wdata_i,
   input  logic                  en_load_i,
   input  logic [EN_W-1:0]       en_wdata_i,
   input  logic                  status_rd_i,
   output logic [TIME_W-1:0]     time_o,
   output logic [STA_W-1:0]      status_o,
   output logic                  irq_n_o
);

   generate
      if (LEAP_EVERY < 0 || (LEAP_EVERY > 0 && (LEAP_EVERY & (LEAP_EVERY - 1)) != 0)) begin : g_bad_leap
         $error("LEAP_EVERY must be 0 or a power of two");
      end
      if (TIME_W != $bits(cal_time_t)) begin : g_bad_pack
         $error("packed time width mismatch");
      end
   endgenerate

   cal_time_t             cur_time;
   cal_time_t             nxt_time;
   cal_time_t             alarm_q;
   logic [NUM_FIELDS-1:0] mask_q;
   logic                  raw_hit;
   logic                  match;
   logic [EN_W-1:0]       irq_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_q <= '0;
         mask_q  <= '0;
      end else begin
         if (alarm_load_i) alarm_q <= cal_time_t'(alarm_wdata_i);
         if (mask_load_i)  mask_q  <= mask_wdata_i;
      end
   end

   cal_counter #(.LEAP_EVERY(LEAP_EVERY)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .load_i     (time_load_i),
      .load_val_i (cal_time_t'(time_wdata_i)),
      .time_o     (cur_time),
      .next_o     (nxt_time)
   );

   alarm_match u_match (
      .cand_i  (nxt_time),
      .alarm_i (alarm_q),
      .mask_i  (mask_q),
      .hit_o   (raw_hit)
   );

   assign match = raw_hit & tick_i & ~time_load_i;

   irq_ctrl u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .match_i    (match),
      .rd_i       (status_rd_i),
      .en_load_i  (en_load_i),
      .en_wdata_i (en_wdata_i),
      .en_o       (irq_en_q),
      .sta_o      (status_o),
      .irq_n_o    (irq_n_o)
   );

   assign time_o = cur_time;

endmodule

// File: rtl/cal_alarm_rtc_chk.sv
module cal_alarm_rtc_chk
   import rtc_cal_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              time_load_i,
   input logic              en_load_i,
   input logic              status_rd_i,
   input logic [TIME_W-1:0] time_o,
   input logic [STA_W-1:0]  status_o,
   input logic              irq_n_o,
   input logic [EN_W-1:0]   irq_en_q
);

   cal_time_t t;
   assign t = cal_time_t'(time_o);

   a_r1_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !time_load_i && t.sec != SEC_LAST) |=> (t.sec == $past(t.sec) + sec_t'(1)));

   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !time_load_i) |=> $stable(time_o));

   a_r2_fields_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (t.sec <= SEC_LAST && t.min <= MIN_LAST && t.hour <= HOUR_LAST && t.wday <= WDAY_LAST
       && t.mday >= MDAY_FIRST && t.month >= MON_FIRST && t.month <= MON_LAST));

   a_r6_alarm_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[STA_ALARM]) |-> $past(tick_i));

   a_r7_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(status_o[STA_ALARM]) && $past(irq_en_q[EN_ONCE]) && !$past(en_load_i))
      |-> !irq_en_q[EN_ALARM]);

   a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd_i && !tick_i) |=> (status_o == '0));

   a_r9_alarm_drives_line: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[STA_ALARM] |-> !irq_n_o);

   a_r9_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == '0) |-> irq_n_o);

endmodule

bind cal_alarm_rtc cal_alarm_rtc_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_i      (tick_i),
   .time_load_i (time_load_i),
   .en_load_i   (en_load_i),
   .status_rd_i (status_rd_i),
   .time_o      (time_o),
   .status_o    (status_o),
   .irq_n_o     (irq_n_o),
   .irq_en_q    (irq_en_q)
);

// File: tb/cal_alarm_rtc_tb_top.sv
`timescale 1ns/1ps
module cal_alarm_rtc_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        time_load_i = 1'b0;
   logic [35:0] time_wdata_i = '0;
   logic        alarm_load_i = 1'b0;
   logic [35:0] alarm_wdata_i = '0;
   logic        mask_load_i = 1'b0;
   logic [6:0]  mask_wdata_i = '0;
   logic        en_load_i = 1'b0;
   logic [2:0]  en_wdata_i = '0;
   logic        status_rd_i = 1'b0;
   logic [35:0] time_o;
   logic [1:0]  status_o;
   logic        irq_n_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cal_alarm_rtc dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .time_load_i(time_load_i), .time_wdata_i(time_wdata_i),
      .alarm_load_i(alarm_load_i), .alarm_wdata_i(alarm_wdata_i),
      .mask_load_i(mask_load_i), .mask_wdata_i(mask_wdata_i),
      .en_load_i(en_load_i), .en_wdata_i(en_wdata_i),
      .status_rd_i(status_rd_i), .time_o(time_o),
      .status_o(status_o), .irq_n_o(irq_n_o)
   );

   function automatic logic [35:0] mk(input int yr, input int mo, input int wd,
                                      input int md, input int hr, input int mi, input int se);
      mk = {yr[6:0], mo[3:0], wd[2:0], md[4:0], hr[4:0], mi[5:0], se[5:0]};
   endfunction

   task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_time(input logic [35:0] v);
      @(negedge clk); time_load_i = 1'b1; time_wdata_i = v;
      @(negedge clk); time_load_i = 1'b0;
   endtask
   task automatic set_alarm(input logic [35:0] v);
      @(negedge clk); alarm_load_i = 1'b1; alarm_wdata_i = v;
      @(negedge clk); alarm_load_i = 1'b0;
   endtask
   task automatic set_mask(input logic [6:0] v);
      @(negedge clk); mask_load_i = 1'b1; mask_wdata_i = v;
      @(negedge clk); mask_load_i = 1'b0;
   endtask
   task automatic set_en(input logic [2:0] v);
      @(negedge clk); en_load_i = 1'b1; en_wdata_i = v;
      @(negedge clk); en_load_i = 1'b0;
   endtask
   task automatic tick1();
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
   endtask
   task automatic rd_clr();
      @(negedge clk); status_rd_i = 1'b1;
      @(negedge clk); status_rd_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R10 time", time_o, mk(0, 1, 0, 1, 0, 0, 0));
      chk("R10 status", 36'(status_o), 36'(0));
      chk("R10 irq_n", 36'(irq_n_o), 36'(1));
   endtask

   task automatic t_rollover();
      set_time(mk(127, 12, 6, 31, 23, 59, 58));
      tick1();
      chk("R1 sec step", time_o, mk(127, 12, 6, 31, 23, 59, 59));
      tick1();
      chk("R1 R3 R4 full wrap", time_o, mk(0, 1, 0, 1, 0, 0, 0));
      set_time(mk(3, 5, 2, 10, 7, 59, 59));
      tick1();
      chk("R1 minute carry", time_o, mk(3, 5, 2, 10, 8, 0, 0));
      set_time(mk(3, 5, 2, 10, 7, 30, 12));
      repeat (4) @(negedge clk);
      chk("R1 hold", time_o, mk(3, 5, 2, 10, 7, 30, 12));
   endtask

   task automatic t_months();
      set_time(mk(4, 2, 1, 28, 23, 59, 59));
      tick1();
      chk("R2 leap feb 28", time_o, mk(4, 2, 2, 29, 0, 0, 0));
      set_time(mk(4, 2, 3, 29, 23, 59, 59));
      tick1();
      chk("R2 leap feb 29", time_o, mk(4, 3, 4, 1, 0, 0, 0));
      set_time(mk(5, 2, 3, 28, 23, 59, 59));
      tick1();
      chk("R2 plain feb", time_o, mk(5, 3, 4, 1, 0, 0, 0));
      set_time(mk(5, 4, 5, 30, 23, 59, 59));
      tick1();
      chk("R2 april", time_o, mk(5, 5, 6, 1, 0, 0, 0));
      set_time(mk(5, 1, 6, 30, 23, 59, 59));
      tick1();
      chk("R2 R3 jan 30", time_o, mk(5, 1, 0, 31, 0, 0, 0));
   endtask

   task automatic t_load_prio();
      @(negedge clk); tick_i = 1'b1; time_load_i = 1'b1; time_wdata_i = mk(9, 9, 1, 9, 9, 9, 9);
      @(negedge clk); tick_i = 1'b0; time_load_i = 1'b0;
      chk("R5 load over tick", time_o, mk(9, 9, 1, 9, 9, 9, 9));
   endtask

   task automatic t_alarm_exact();
      set_mask(7'b0);
      set_en(3'b001);
      set_alarm(mk(5, 6, 3, 15, 10, 20, 31));
      set_time(mk(5, 6, 3, 15, 10, 20, 30));
      rd_clr();
      tick1();
      chk("R6 exact hit", 36'(status_o[0]), 36'(1));
      chk("R9 alarm line", 36'(irq_n_o), 36'(0));
      rd_clr();
      chk("R8 read clears", 36'(status_o), 36'(0));
      chk("R9 line released", 36'(irq_n_o), 36'(1));
      set_time(mk(5, 6, 3, 15, 10, 20, 20));
      tick1();
      chk("R6 miss", 36'(status_o[0]), 36'(0));
   endtask

   task automatic t_alarm_masks();
      set_en(3'b001);
      set_mask(7'b1111110);
      set_alarm(mk(0, 1, 0, 1, 0, 0, 45));
      set_time(mk(9, 9, 2, 9, 9, 9, 44));
      rd_clr();
      tick1();
      chk("R6 seconds only", 36'(status_o[0]), 36'(1));
      set_mask(7'b0010000);
      set_alarm(mk(7, 3, 5, 12, 6, 40, 1));
      set_time(mk(7, 3, 3, 12, 6, 40, 0));
      rd_clr();
      tick1();
      chk("R6 weekday masked", 36'(status_o[0]), 36'(1));
      set_mask(7'b0);
      set_time(mk(7, 3, 3, 12, 6, 40, 0));
      rd_clr();
      tick1();
      chk("R6 weekday compared", 36'(status_o[0]), 36'(0));
   endtask

   task automatic t_oneshot();
      set_mask(7'b0);
      set_alarm(mk(2, 2, 2, 2, 2, 2, 3));
      set_en(3'b101);
      set_time(mk(2, 2, 2, 2, 2, 2, 2));
      rd_clr();
      tick1();
      chk("R7 once first", 36'(status_o[0]), 36'(1));
      rd_clr();
      set_time(mk(2, 2, 2, 2, 2, 2, 2));
      tick1();
      chk("R7 once disarmed", 36'(status_o[0]), 36'(0));
      chk("R7 line idle", 36'(irq_n_o), 36'(1));
      set_en(3'b001);
      set_time(mk(2, 2, 2, 2, 2, 2, 2));
      tick1();
      rd_clr();
      set_time(mk(2, 2, 2, 2, 2, 2, 2));
      tick1();
      chk("R7 periodic repeats", 36'(status_o[0]), 36'(1));
      set_en(3'b000);
      rd_clr();
      set_time(mk(2, 2, 2, 2, 2, 2, 2));
      tick1();
      chk("R6 disabled no status", 36'(status_o[0]), 36'(0));
   endtask

   task automatic t_tick_irq();
      set_en(3'b000);
      rd_clr();
      tick1();
      chk("R8 tick status", 36'(status_o), 36'(2));
      chk("R9 tick masked", 36'(irq_n_o), 36'(1));
      set_en(3'b010);
      chk("R9 tick enabled", 36'(irq_n_o), 36'(0));
      @(negedge clk); tick_i = 1'b1; status_rd_i = 1'b1;
      @(negedge clk); tick_i = 1'b0; status_rd_i = 1'b0;
      chk("R8 event beats read", 36'(status_o[1]), 36'(1));
      rd_clr();
      chk("R8 tick cleared", 36'(status_o), 36'(0));
      chk("R9 line high", 36'(irq_n_o), 36'(1));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rollover();
      t_months();
      t_load_prio();
      t_alarm_exact();
      t_alarm_masks();
      t_oneshot();
      t_tick_irq();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule